// File: doc/BRIEF.md
# Serial flash write-protection checker

This block sits behind the command decoder of a serial NOR flash and decides, for each program, erase or register-write command, whether the command may run. It covers 1024 sectors and applies three independent guards. The first is a write enable latch. The second is a block-protected region whose size and anchor come from a four-bit code and an anchor select. The third is a pair of lock bits per sector: a write-lock bit and a lock-down bit. A command also fails if the clock pulses it carried do not form whole bytes.

The decoder presents one command strobe per cycle, together with the target sector, the clock-pulse count seen while chip select was low, and a five-bit data field. One cycle later the block answers with either a grant pulse or a deny pulse. The write enable latch, the protection code, the anchor select and the lock bits of the addressed sector can be read back at the ports at all times. The active-low reset stands for a device reset or a power cycle. It clears the latch and every lock bit. It leaves the protection code and the anchor alone, because those are non-volatile.

Top module: `flash_wprot`

## Requirements
- R1: The write enable strobe sets `wel`. A program, erase, status-write or lock-write command that arrives while `wel` is 0 is denied.
- R2: A program, erase, status-write or lock-write command is denied when `pulses[2:0]` is not zero, that is when the pulse count is not a whole multiple of eight.
- R3: Every program, erase, status-write or lock-write command clears `wel` in the following cycle, whether the command was granted or denied.
- R4: When the protection code is 0, no sector is protected by the block-protect region.
- R5: With `tb` = 0, a code n from 1 to 10 protects the 2^(n-1) highest sectors, ending at sector 1023. Codes 11 to 15 protect all sectors.
- R6: With `tb` = 1, the region has the same size but starts at sector 0 and covers sectors 0 to 2^(n-1)-1.
- R7: A program or erase command aimed at a sector whose write-lock bit is 1 is denied. A sector whose write-lock bit is 0, and which lies outside the protected region, is granted when R1 and R2 are met.
- R8: A granted lock-write command loads `din[1:0]` into the addressed sector, with bit 1 as lock-down and bit 0 as write-lock. While that sector's lock-down bit is 1, lock-write commands for it are denied and its lock bits stay unchanged.
- R9: A granted status-write command loads `din[3:0]` into the protection code `bp` and `din[4]` into `tb`. A denied one leaves both unchanged.
- R10: Reset clears `wel` and both lock bits of every sector. It keeps `bp` and `tb` unchanged.
- R11: Every program, erase, status-write or lock-write command produces exactly one of `grant` or `deny`, as a single-cycle pulse in the cycle after the strobe. The write enable strobe produces neither.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset or power-cycle pulse, asynchronous |
| cmd_wren | input | 1 | Write enable command strobe |
| cmd_prog | input | 1 | Program command strobe |
| cmd_erase | input | 1 | Erase command strobe |
| cmd_wrsr | input | 1 | Status (protection code) write strobe |
| cmd_wrlk | input | 1 | Sector lock write strobe |
| sect | input | 10 | Target sector index; also selects the lock readback |
| pulses | input | 16 | Clock pulses counted while chip select was low |
| din | input | 5 | Write data: {tb, code} for status write, {lock-down, write-lock} in bits 1:0 for lock write |
| grant | output | 1 | Command was executed (one-cycle pulse) |
| deny | output | 1 | Command was rejected (one-cycle pulse) |
| wel | output | 1 | Write enable latch |
| bp | output | 4 | Block-protect code |
| tb | output | 1 | Region anchor: 0 = top of array, 1 = bottom |
| lk_rd | output | 2 | Lock bits of sector `sect`: {lock-down, write-lock} |

## Verification
The assertions assume that the decoder raises at most one command strobe in any cycle, and they check that assumption as an input property. They also assume that `sect` is held steady whenever the freeze of a locked-down sector is checked from one cycle to the next. The bench issues each command as a single strobe for one cycle and keeps the sector index fixed until the verdict has been read, so both assumptions always hold. Protection-region checks probe sectors on both sides of each region edge, at both anchors and for every code.

// File: rtl/flash_wprot.sv
module flash_wprot #(
  parameter int SECT_W = 10,
  parameter int CNT_W  = 16,
  parameter logic [3:0] BP_INIT = 4'd0,
  parameter logic       TB_INIT = 1'b0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              cmd_wren,
  input  logic              cmd_prog,
  input  logic              cmd_erase,
  input  logic              cmd_wrsr,
  input  logic              cmd_wrlk,
  input  logic [SECT_W-1:0] sect,
  input  logic [CNT_W-1:0]  pulses,
  input  logic [4:0]        din,
  output logic              grant,
  output logic              deny,
  output logic              wel,
  output logic [3:0]        bp,
  output logic              tb,
  output logic [1:0]        lk_rd
);
  localparam int NSECT = 1 << SECT_W;

  logic [1:0]        lk_q [NSECT];
  logic [3:0]        bp_q = BP_INIT;
  logic              tb_q = TB_INIT;
  logic              wel_q, grant_q, deny_q;
  logic [3:0]        shamt;
  logic [SECT_W-1:0] hi, edge_mask;
  logic              aligned, base_ok, bp_hit, mem_ok, lk_ok, wr_any, verdict;

  assign lk_rd   = lk_q[sect];
  assign aligned = (pulses[2:0] == 3'd0);
  assign base_ok = wel_q & aligned;
  assign wr_any  = cmd_prog | cmd_erase | cmd_wrsr | cmd_wrlk;

  // region covers sectors whose bits above (code-1) are all ones (top) or all zeros (bottom)
  assign shamt     = bp_q - 4'd1;
  assign hi        = sect >> shamt;
  assign edge_mask = {SECT_W{1'b1}} >> shamt;
  assign bp_hit    = (bp_q != 4'd0) && (tb_q ? (hi == '0) : (hi == edge_mask));

  assign mem_ok  = base_ok & ~bp_hit & ~lk_rd[0];
  assign lk_ok   = base_ok & ~lk_rd[1];
  assign verdict = ((cmd_prog | cmd_erase) & mem_ok) | (cmd_wrsr & base_ok) | (cmd_wrlk & lk_ok);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      wel_q   <= 1'b0;
      grant_q <= 1'b0;
      deny_q  <= 1'b0;
      for (int i = 0; i < NSECT; i++) lk_q[i] <= 2'b00;
    end else begin
      grant_q <= wr_any & verdict;
      deny_q  <= wr_any & ~verdict;
      if (wr_any)        wel_q <= 1'b0;
      else if (cmd_wren) wel_q <= 1'b1;
      if (cmd_wrlk && lk_ok) lk_q[sect] <= din[1:0];
    end
  end

  always_ff @(posedge clk) begin
    if (rst_n && cmd_wrsr && base_ok) begin
      bp_q <= din[3:0];
      tb_q <= din[4];
    end
  end

  assign grant = grant_q;
  assign deny  = deny_q;
  assign wel   = wel_q;
  assign bp    = bp_q;
  assign tb    = tb_q;

  a_r11_one_strobe: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({cmd_wren, cmd_prog, cmd_erase, cmd_wrsr, cmd_wrlk}));
  a_r11_one_verdict: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> (grant ^ deny));
  a_r11_quiet: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_any |=> !(grant || deny));
  a_r1_needs_wel: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any && !wel |=> deny);
  a_r2_needs_align: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any && (pulses[2:0] != 3'd0) |=> deny);
  a_r3_wel_drops: assert property (@(posedge clk) disable iff (!rst_n)
    wr_any |=> !wel);
  a_r8_frozen: assert property (@(posedge clk) disable iff (!rst_n)
    $past(lk_rd[1]) && $stable(sect) |-> $stable(lk_rd));
endmodule

// File: tb/flash_wprot_tb.sv
module flash_wprot_tb;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        cmd_wren = 0, cmd_prog = 0, cmd_erase = 0, cmd_wrsr = 0, cmd_wrlk = 0;
  logic [9:0]  sect = '0;
  logic [15:0] pulses = '0;
  logic [4:0]  din = '0;
  logic        grant, deny, wel, tb;
  logic [3:0]  bp;
  logic [1:0]  lk_rd;
  int total = 0, bad = 0;
  bit done = 0;

  always #10 clk = ~clk;

  flash_wprot u_dut (.clk(clk), .rst_n(rst_n), .cmd_wren(cmd_wren), .cmd_prog(cmd_prog),
    .cmd_erase(cmd_erase), .cmd_wrsr(cmd_wrsr), .cmd_wrlk(cmd_wrlk), .sect(sect),
    .pulses(pulses), .din(din), .grant(grant), .deny(deny), .wel(wel), .bp(bp), .tb(tb),
    .lk_rd(lk_rd));

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    total++;
    if (!ok) begin
      bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  // kind: 0 wren, 1 prog, 2 erase, 3 status write, 4 lock write
  task automatic issue(input int kind, input int s, input int p, input int d,
                       output bit g, output bit n);
    @(negedge clk);
    sect = s[9:0]; pulses = p[15:0]; din = d[4:0];
    cmd_wren = (kind == 0); cmd_prog = (kind == 1); cmd_erase = (kind == 2);
    cmd_wrsr = (kind == 3); cmd_wrlk = (kind == 4);
    @(negedge clk);
    g = grant; n = deny;
    {cmd_wren, cmd_prog, cmd_erase, cmd_wrsr, cmd_wrlk} = '0;
  endtask

  task automatic pulse_reset();
    @(negedge clk); rst_n = 0;
    @(negedge clk); @(negedge clk); rst_n = 1;
  endtask

  function automatic bit prot(input int code, input bit t, input int s);
    int span;
    if (code == 0) return 0;
    if (code - 1 >= 10) return 1;
    span = 1 << (code - 1);
    return t ? (s < span) : (s >= 1024 - span);
  endfunction

  task automatic set_status(input int code, input bit t);
    bit g, n;
    issue(0, 0, 8, 0, g, n);
    issue(3, 0, 16, {t, code[3:0]}, g, n);
    chk(g && !n, "R9 status write granted", g, 1);
    chk(bp == code[3:0] && tb == t, "R9 status readback", {tb, bp}, {t, code[3:0]});
  endtask

  task automatic t_reset_state();
    chk(wel == 0, "R10 wel after reset", wel, 0);
    chk(!grant && !deny, "R11 no verdict after reset", {grant, deny}, 0);
    chk(lk_rd == 2'b00, "R10 lock bits after reset", lk_rd, 0);
    chk(bp == 4'd0 && tb == 0, "R10 initial code", {tb, bp}, 0);
  endtask

  task automatic t_write_enable();
    bit g, n;
    issue(1, 5, 8, 0, g, n);
    chk(n && !g, "R1 program without wel denied", {g, n}, 1);
    issue(0, 5, 8, 0, g, n);
    chk(wel == 1, "R1 wren sets wel", wel, 1);
    chk(!g && !n, "R11 wren gives no verdict", {g, n}, 0);
    issue(1, 5, 8, 0, g, n);
    chk(g && !n, "R4 code 0 program granted", {g, n}, 2);
    chk(wel == 0, "R3 wel cleared after grant", wel, 0);
    issue(0, 5, 8, 0, g, n);
    issue(2, 1023, 24, 0, g, n);
    chk(g && !n, "R4 code 0 erase top sector granted", {g, n}, 2);
  endtask

  task automatic t_alignment();
    bit g, n;
    issue(0, 3, 8, 0, g, n);
    issue(1, 3, 37, 0, g, n);
    chk(n && !g, "R2 misaligned program denied", {g, n}, 1);
    chk(wel == 0, "R3 wel cleared after deny", wel, 0);
    issue(0, 3, 8, 0, g, n);
    issue(3, 0, 12, 5'h13, g, n);
    chk(n && !g, "R2 misaligned status write denied", {g, n}, 1);
    chk(bp == 0 && tb == 0, "R9 denied status write keeps code", {tb, bp}, 0);
    issue(3, 0, 16, 5'h13, g, n);
    chk(n && !g, "R1 status write without wel denied", {g, n}, 1);
    chk(bp == 0 && tb == 0, "R9 code kept after no-wel write", {tb, bp}, 0);
  endtask

  task automatic t_regions();
    bit g, n;
    int probes[6];
    for (int t = 0; t < 2; t++) begin
      for (int code = 1; code < 16; code++) begin
        int span = (code - 1 >= 10) ? 1024 : (1 << (code - 1));
        set_status(code, t[0]);
        probes = '{0, span - 1, span, 1023 - span, 1024 - span, 1023};
        for (int k = 0; k < 6; k++) begin
          int s = probes[k];
          bit exp_deny;
          if (s < 0) s = 0;
          if (s > 1023) s = 1023;
          exp_deny = prot(code, t[0], s);
          issue(0, s, 8, 0, g, n);
          issue(2, s, 32, 0, g, n);
          if (t == 0) chk(n == exp_deny && g != exp_deny, "R5 top region", s * 4 + {g, n}, s * 4 + {!exp_deny, exp_deny});
          else        chk(n == exp_deny && g != exp_deny, "R6 bottom region", s * 4 + {g, n}, s * 4 + {!exp_deny, exp_deny});
        end
      end
    end
    set_status(0, 0);
  endtask

  task automatic t_locks();
    bit g, n;
    issue(0, 7, 8, 0, g, n);
    issue(4, 7, 8, 2'b01, g, n);
    chk(g && lk_rd == 2'b01, "R8 lock write loads write-lock", lk_rd, 1);
    issue(0, 7, 8, 0, g, n);
    issue(1, 7, 8, 0, g, n);
    chk(n && !g, "R7 write-locked sector denied", {g, n}, 1);
    issue(0, 8, 8, 0, g, n);
    issue(1, 8, 8, 0, g, n);
    chk(g && !n, "R7 neighbour sector granted", {g, n}, 2);
    issue(0, 7, 8, 0, g, n);
    issue(4, 7, 8, 2'b00, g, n);
    chk(g && lk_rd == 2'b00, "R8 write-lock reversible", lk_rd, 0);
    issue(0, 7, 8, 0, g, n);
    issue(4, 7, 8, 2'b11, g, n);
    chk(g && lk_rd == 2'b11, "R8 lock-down set", lk_rd, 3);
    issue(0, 7, 8, 0, g, n);
    issue(4, 7, 8, 2'b00, g, n);
    chk(n && !g, "R8 lock write on locked-down sector denied", {g, n}, 1);
    chk(lk_rd == 2'b11, "R8 locked-down bits unchanged", lk_rd, 3);
    issue(0, 7, 8, 0, g, n);
    issue(2, 7, 8, 0, g, n);
    chk(n && !g, "R7 locked-down sector erase denied", {g, n}, 1);
  endtask

  task automatic t_reset_keep();
    bit g, n;
    set_status(1, 1);
    pulse_reset();
    sect = 7;
    #1;
    chk(lk_rd == 2'b00, "R10 reset clears lock-down", lk_rd, 0);
    chk(wel == 0, "R10 reset clears wel", wel, 0);
    chk(bp == 4'd1 && tb == 1, "R10 reset keeps code", {tb, bp}, 17);
    issue(0, 7, 8, 0, g, n);
    issue(1, 7, 8, 0, g, n);
    chk(g && !n, "R7 unlocked after reset", {g, n}, 2);
    issue(0, 0, 8, 0, g, n);
    issue(1, 0, 8, 0, g, n);
    chk(n && !g, "R6 sector 0 still protected after reset", {g, n}, 1);
    set_status(0, 0);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
    t_reset_state();
    t_write_enable();
    t_alignment();
    t_regions();
    t_locks();
    t_reset_keep();
    done = 1;
  end

  initial begin
    fork
      wait (done);
      begin
        repeat (100000) @(posedge clk);
        total++; bad++;
        $display("FAIL watchdog actual=0 expected=1");
      end
    join_any
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule